// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. An asynchronous pin is brought into the timer clock domain, cleaned by a programmable noise filter, and turned into rising and falling edge events. A polarity setting decides which edges count. A source selector chooses the event stream from one of four places: this channel's own edges, the edges of a neighbouring channel's filtered level, a synchronous trigger pulse, or nothing at all. A prescaler then passes only every 1st, 2nd, 4th or 8th qualified event.

Each effective event copies the free-running 16-bit timer counter, which is an input to the block, into a capture register and sets a capture flag. If the flag is still set when a new capture arrives, an over-capture flag is raised as well. The interrupt request is the capture flag gated by an enable. The channel's own filtered level is also an output, so that a neighbouring channel can use it as its cross-channel source.

Top module: `icap_channel`

## Requirements
- R1: The pin passes through two synchronizer flops and then the filter. For a clean level change on `ch_i` driven in the cycle where the counter reads C0, the capture holds C0+2+N. The flag is still 0 after 2+N clock edges and reads 1 after 3+N edges. N is `flt_len_i`+1, so a code of 0 means no filtering.
- R2: The filtered level changes only after N consecutive synchronized samples that differ from it. A pulse lasting fewer than N cycles causes no capture.
- R3: Polarity: `pol_i[0]`=1 enables rising edges and `pol_i[1]`=1 enables falling edges. 2'b11 selects both edges and 2'b00 selects none. Rising and falling events are never active together.
- R4: Source: `src_i`=0 selects the own filtered edges. 1 selects edges of `nbr_filt_i`, which is treated as already synchronous and uses the same polarity. 2 selects `trig_i` pulses, which ignore polarity. 3 selects no source. Sources that are not selected cause no capture.
- R5: Prescaler: with `psc_i`=k, only every 2^k-th qualified event after capture is enabled becomes effective. The first effective event is the 2^k-th.
- R6: An effective event stores the counter value present in that cycle into `cap_val_o` and sets `flag_o` at the next clock edge. A trigger pulse or a neighbour edge is therefore captured with the counter value of its own cycle.
- R7: `irq_o` is 1 exactly when `flag_o` is 1 and `ie_i` is 1.
- R8: A one-cycle `flag_clr_i` strobe clears `flag_o`. If a capture happens in the same cycle, the capture wins and the flag stays set.
- R9: A capture while `flag_o` is already 1 sets `ovr_o`. `ovr_o` stays set until a `ovr_clr_i` strobe, and clearing it leaves `flag_o` unchanged.
- R10: While `cap_en_i` is 0, no capture happens and the prescaler event count is held at zero.
- R11: After reset, `cap_val_o`, `flag_o`, `ovr_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ch_i | input | 1 | Asynchronous channel pin |
| nbr_filt_i | input | 1 | Filtered level of the neighbouring channel (synchronous) |
| trig_i | input | 1 | Internal trigger pulse (synchronous) |
| cap_en_i | input | 1 | Capture enable |
| flt_len_i | input | 4 | Filter length code, N = code+1 |
| pol_i | input | 2 | Edge enables: bit0 rising, bit1 falling |
| src_i | input | 2 | Source select: 0 own, 1 neighbour, 2 trigger, 3 none |
| psc_i | input | 2 | Prescaler code, ratio 2^code |
| ie_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Capture flag clear strobe |
| ovr_clr_i | input | 1 | Over-capture flag clear strobe |
| cnt_i | input | 16 | Free-running timer counter |
| cap_val_o | output | 16 | Captured counter value |
| flag_o | output | 1 | Capture flag |
| ovr_o | output | 1 | Over-capture flag |
| irq_o | output | 1 | Interrupt request |
| filt_o | output | 1 | Own filtered level |

## Verification
Results on the pin path arrive a fixed number of edges after the change: the synchronizer takes two, the filter takes N, and the flag register takes one more. The bench records the counter when it drives the pin and checks the flag both one edge before and exactly at edge 3+N. It also checks that the captured value is that recorded count plus 2+N. Trigger and neighbour events skip the synchronizer and the filter, so the bench samples them one edge after they are driven and expects the counter value of the drive cycle. All sampling is done on the falling clock edge.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    SRC_OWN = 2'd0,
    SRC_NBR = 2'd1,
    SRC_TRG = 2'd2,
    SRC_OFF = 2'd3
  } icap_src_e;

  // Edge qualification: bit0 enables rising, bit1 enables falling.
  function automatic logic edge_pick(input logic [1:0] pol, input logic rise,
                                     input logic fall);
    return (pol[0] & rise) | (pol[1] & fall);
  endfunction

  // Prescaler ratio for a code: 2^code.
  function automatic int unsigned psc_ratio(input int unsigned code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             q_o
);
  logic [LEN_W-1:0] run_q;
  logic             lvl_q;
  logic             accept;

  // The new level is taken on the N-th consecutive differing sample.
  assign accept = (d_i != lvl_q) && (run_q >= len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (d_i == lvl_q) begin
      run_q <= '0;
    end else if (accept) begin
      lvl_q <= d_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign q_o = lvl_q;

  // R2: a level change is always a move to the sampled value.
  p_filt_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(d_i)));
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  // R3: both edge events can never be active in the same cycle.
  p_edge_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/icap_prescale.sv
module icap_prescale #(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              evt_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              eff_o
);
  import icap_pkg::*;
  localparam int CW = (1 << CODE_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last  = CW'(psc_ratio(32'(code_i)) - 1);
  assign eff_o = en_i && evt_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (eff_o)  cnt_q <= '0;
    else if (evt_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R10: the event count starts from zero whenever capture is re-enabled.
  p_psc_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (cnt_q == '0));
endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 4,
  parameter int PSC_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ch_i,
  input  logic             nbr_filt_i,
  input  logic             trig_i,
  input  logic             cap_en_i,
  input  logic [LEN_W-1:0] flt_len_i,
  input  logic [1:0]       pol_i,
  input  logic [1:0]       src_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             ie_i,
  input  logic             flag_clr_i,
  input  logic             ovr_clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             flag_o,
  output logic             ovr_o,
  output logic             irq_o,
  output logic             filt_o
);
  import icap_pkg::*;

  // Named internal events, brought out for the assertions.
  logic sync_lvl, own_rise, own_fall, nbr_rise, nbr_fall;
  logic qual_evt, eff_evt;
  logic [CNT_W-1:0] cap_q;
  logic flag_q, ovr_q;

  icap_sync #(.STAGES(STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ch_i), .q_o(sync_lvl));

  icap_filter #(.LEN_W(LEN_W)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_lvl), .len_i(flt_len_i),
    .q_o(filt_o));

  icap_edge u_own_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(filt_o),
    .rise_o(own_rise), .fall_o(own_fall));

  icap_edge u_nbr_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(nbr_filt_i),
    .rise_o(nbr_rise), .fall_o(nbr_fall));

  always_comb begin
    unique case (icap_src_e'(src_i))
      SRC_OWN: qual_evt = edge_pick(pol_i, own_rise, own_fall);
      SRC_NBR: qual_evt = edge_pick(pol_i, nbr_rise, nbr_fall);
      SRC_TRG: qual_evt = trig_i;
      default: qual_evt = 1'b0;
    endcase
  end

  icap_prescale #(.CODE_W(PSC_W)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cap_en_i), .evt_i(qual_evt),
    .code_i(psc_i), .eff_o(eff_evt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (eff_evt) cap_q <= cnt_i;
      flag_q <= eff_evt | (flag_q & ~flag_clr_i);
      ovr_q  <= (eff_evt & flag_q) | (ovr_q & ~ovr_clr_i);
    end
  end

  assign cap_val_o = cap_q;
  assign flag_o    = flag_q;
  assign ovr_o     = ovr_q;
  assign irq_o     = flag_q & ie_i;

  // R6: an effective event latches the counter and sets the flag.
  p_cap_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_evt |=> (flag_o && cap_val_o == $past(cnt_i)));
  // R9: a capture on a set flag raises the over-capture flag.
  p_ovr_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_evt && flag_o) |=> ovr_o);
  // R8: a clear without a concurrent capture drops the flag.
  p_flag_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !eff_evt) |=> !flag_o);
  // R10: no effective event while capture is disabled.
  p_no_cap_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |-> !eff_evt);
  // R4: the unused source code never yields an event.
  p_src_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == 2'd3) |-> !eff_evt);
endmodule

// File: tb/tb_icap_channel.sv
module tb_icap_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch = 1'b0, nbr = 1'b0, trig = 1'b0, cap_en = 1'b1;
  logic [3:0]  flt = '0;
  logic [1:0]  pol = 2'b01, src = 2'd0, psc = 2'd0;
  logic        ie = 1'b1, fclr = 1'b0, oclr = 1'b0;
  logic [15:0] cnt = '0;
  logic [15:0] cap;
  logic        flag, ovr, irq, filt;
  int          n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 16'd1;

  icap_channel dut (
    .clk_i(clk), .rst_ni(rst_n), .ch_i(ch), .nbr_filt_i(nbr), .trig_i(trig),
    .cap_en_i(cap_en), .flt_len_i(flt), .pol_i(pol), .src_i(src), .psc_i(psc),
    .ie_i(ie), .flag_clr_i(fclr), .ovr_clr_i(oclr), .cnt_i(cnt),
    .cap_val_o(cap), .flag_o(flag), .ovr_o(ovr), .irq_o(irq), .filt_o(filt));

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    fclr = 1'b1; oclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0; oclr = 1'b0;
  endtask

  // Drives a pin level and checks latency and captured value (R1, R3).
  task automatic pin_case(input int f, input logic [1:0] p, input logic lvl,
                          input logic expect_cap);
    logic [15:0] c0;
    int n;
    flt = 4'(f); pol = p; n = f + 1;
    clear_all();
    ch = lvl; c0 = cnt;
    repeat (2 + n) @(negedge clk);
    chk("R1 flag early", 32'(flag), 32'd0);
    @(negedge clk);
    chk("R3 edge polarity", 32'(flag), 32'(expect_cap));
    chk("R7 irq", 32'(irq), 32'(expect_cap));
    if (expect_cap) chk("R1 capture value", 32'(cap), 32'(16'(c0 + 16'(2 + n))));
    repeat (n + 4) @(negedge clk);
  endtask

  // One trigger pulse; returns the counter value of its cycle.
  task automatic trig_pulse(output logic [15:0] c0);
    trig = 1'b1; c0 = cnt;
    @(negedge clk);
    trig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    chk("R11 cap reset", 32'(cap), 32'd0);
    chk("R11 flag reset", 32'(flag), 32'd0);
    chk("R11 ovr reset", 32'(ovr), 32'd0);
    chk("R11 irq reset", 32'(irq), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1/R3 sweep over filter length and polarity.
    foreach (flt_set[i]) ;
    for (int fi = 0; fi < 5; fi++) begin
      int f;
      f = (fi == 0) ? 0 : (fi == 1) ? 1 : (fi == 2) ? 2 : (fi == 3) ? 5 : 15;
      for (int p = 1; p < 4; p++) begin
        pin_case(f, 2'(p), 1'b1, p[0]);
        pin_case(f, 2'(p), 1'b0, p[1]);
      end
    end

    // R2: glitch rejection with N=4.
    flt = 4'd3; pol = 2'b11; clear_all();
    ch = 1'b1; repeat (3) @(negedge clk); ch = 1'b0;
    repeat (15) @(negedge clk);
    chk("R2 short pulse rejected", 32'(flag), 32'd0);
    ch = 1'b1; repeat (4) @(negedge clk); ch = 1'b0;
    repeat (15) @(negedge clk);
    chk("R2 full pulse accepted", 32'(flag), 32'd1);
    flt = 4'd0;

    // R4: neighbour source.
    src = 2'd1; pol = 2'b01; clear_all();
    nbr = 1'b1; c0 = cnt; @(negedge clk);
    chk("R4 neighbour rise flag", 32'(flag), 32'd1);
    chk("R6 neighbour value", 32'(cap), 32'(c0));
    clear_all();
    nbr = 1'b0; repeat (2) @(negedge clk);
    chk("R4 neighbour fall ignored", 32'(flag), 32'd0);
    ch = 1'b1; repeat (10) @(negedge clk);
    chk("R4 own pin ignored", 32'(flag), 32'd0);
    ch = 1'b0; repeat (10) @(negedge clk);

    // R4: trigger source and disabled source.
    src = 2'd2; clear_all();
    trig_pulse(c0);
    chk("R4 trigger flag", 32'(flag), 32'd1);
    chk("R6 trigger value", 32'(cap), 32'(c0));
    src = 2'd3; clear_all();
    trig_pulse(c0); nbr = 1'b1; @(negedge clk); nbr = 1'b0; @(negedge clk);
    chk("R4 source off", 32'(flag), 32'd0);

    // R5: prescaler sweep on trigger pulses.
    src = 2'd2;
    for (int k = 0; k < 4; k++) begin
      psc = 2'(k); cap_en = 1'b0; @(negedge clk); cap_en = 1'b1;
      clear_all();
      for (int i = 1; i <= 2 * (1 << k); i++) begin
        logic exp_cap;
        exp_cap = ((i % (1 << k)) == 0);
        trig_pulse(c0);
        chk("R5 prescaler", 32'(flag), 32'(exp_cap));
        if (exp_cap) begin
          chk("R6 prescaled value", 32'(cap), 32'(c0));
          clear_all();
        end
      end
    end

    // R10: disabled capture and prescaler restart.
    psc = 2'd0; cap_en = 1'b0; clear_all();
    trig_pulse(c0);
    chk("R10 disabled no capture", 32'(flag), 32'd0);
    psc = 2'd1; cap_en = 1'b1; @(negedge clk);
    trig_pulse(c0);
    cap_en = 1'b0; @(negedge clk); cap_en = 1'b1; @(negedge clk);
    trig_pulse(c0);
    chk("R10 count restarted", 32'(flag), 32'd0);
    trig_pulse(c0);
    chk("R10 second after restart", 32'(flag), 32'd1);
    psc = 2'd0;

    // R9: over-capture.
    clear_all();
    trig_pulse(c0); trig_pulse(c0);
    chk("R9 over-capture set", 32'(ovr), 32'd1);
    chk("R6 latest value", 32'(cap), 32'(c0));
    oclr = 1'b1; @(negedge clk); oclr = 1'b0;
    chk("R9 ovr cleared", 32'(ovr), 32'd0);
    chk("R9 flag kept", 32'(flag), 32'd1);

    // R8: capture wins over clear.
    trig = 1'b1; fclr = 1'b1; @(negedge clk); trig = 1'b0; fclr = 1'b0;
    chk("R8 capture beats clear", 32'(flag), 32'd1);
    chk("R9 ovr on concurrent clear", 32'(ovr), 32'd1);
    fclr = 1'b1; @(negedge clk); fclr = 1'b0;
    chk("R8 flag cleared", 32'(flag), 32'd0);

    // R7: interrupt gating.
    trig_pulse(c0); ie = 1'b0; #1;
    chk("R7 irq masked", 32'(irq), 32'd0);
    ie = 1'b1; #1;
    chk("R7 irq enabled", 32'(irq), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int flt_set[1];
endmodule